// File: doc/BRIEF.md
# Fractional-Rate Master Time Counter

This block produces a free-running 64-bit time count that advances at a fixed nominal rate, 6.144 MHz, whatever the frequency of the clock that drives it. Every clock cycle a fractional accumulator adds a programmable step value. When the running sum reaches a programmable modulus, the block removes the modulus from the sum and the count advances by exactly one. The average count rate is therefore the input clock rate multiplied by step/modulus. Some common pairs are 4/25 at 38.4 MHz, 8/25 at 19.2 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz, 192/625 at 20 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz. When the slow reference is derived from the system clock, the pair is 75/244.

Local timer peripherals take the count directly from `count_o`. Software sets the ratio and reads the count through a small word-addressed register port. The 64-bit count is read as two 32-bit words. A read of the low word captures the high word at the same time, so a two-read sequence cannot tear across a carry.

The accumulator is controlled by a four-state machine:
- **RESTART**: the accumulator is cleared and the count does not advance. This state follows reset and every ratio write.
- **RUN**: used when 0 < step < modulus. The block accumulates and advances the count on overflow.
- **FULL**: used when step >= modulus and the modulus is not zero. The count advances every cycle.
- **STOP**: used when the modulus is zero. The count holds.

Transitions:
- A ratio write in any state leads to RESTART.
- With no write, every state moves to the class of the current ratio: STOP if the modulus is zero, FULL if step >= modulus, and RUN otherwise.

Top module: `rt_frac_counter`

## Requirements
- R1: After reset, the count equals the parameter `CNT_INIT` (default zero). The step field reads 4, the modulus field reads 25, the spare bits read zero, and the first cycle after reset is a restart cycle.
- R2: In RUN, each cycle adds the step to the accumulator. When the sum is at least the modulus, the modulus is subtracted and the count rises by one. N cycles after a restart cycle, the count has risen by exactly floor(N*step/modulus).
- R3: `count_o` never changes by more than one per cycle and never decreases, apart from the natural 64-bit wrap.
- R4: While the modulus field is zero, the count holds its value.
- R5: While the step field is at least a nonzero modulus, the count rises by one every cycle.
- R6: A write to the step register (byte offset 0x10) or the modulus register (0x14) loads bits [11:0] as the new field value. The cycle after the write is a restart cycle (accumulator cleared, no advance), and the new ratio applies from the cycle after that. During the write cycle itself the old ratio still applies.
- R7: Bits [31:12] of both ratio registers are plain storage. They read back as written and have no effect on the count rate.
- R8: A read with `bus_rd` high returns its data on `bus_rdata` from the next cycle on, and `bus_rdata` holds until the next read. Offset 0x00 returns count bits [31:0] as they stood in the read cycle. Offset 0x04 returns the count bits [63:32] captured by the most recent low-word read; after reset this value is `CNT_INIT[63:32]`.
- R9: Writes to offsets other than 0x10 and 0x14 change nothing and start no restart cycle. Reads of unmapped offsets return zero.
- R10: A low-word read followed by a high-word read returns a consistent 64-bit value, even when a carry into bit 32 occurs between the two reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of any supported frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after `bus_rd` |
| count_o | output | 64 | Free-running time count to the local timers |

## Verification
A wrong accumulator value shows up as a drift of `count_o` against an arithmetic floor(N*step/modulus) reference. For any ratio, the drift appears within one modulus period. A wrong state, such as a missed restart or an advance while stopped, shows up as a single-count offset on the very next cycle. The bench therefore compares the count on every cycle across a sweep of small step/modulus pairs. A tear in the read path only shows when a carry falls between the two word reads. For that reason the bench starts the count just below a 32-bit boundary and reads across it.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
    // Accumulator control states
    typedef enum logic [1:0] {
        ST_RESTART = 2'd0,
        ST_RUN     = 2'd1,
        ST_FULL    = 2'd2,
        ST_STOP    = 2'd3
    } acc_state_e;

    // Register byte offsets (the ratio offsets are fixed by software usage)
    localparam int OFS_CNT_LO = 'h00;
    localparam int OFS_CNT_HI = 'h04;
    localparam int OFS_STEP   = 'h10;
    localparam int OFS_MOD    = 'h14;

    // Reset ratio: 38.4 MHz input -> 6.144 MHz count
    localparam int DEF_STEP = 4;
    localparam int DEF_MOD  = 25;
endpackage

// File: rtl/fcnt_regs.sv
module fcnt_regs
    import fcnt_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5,
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [FRAC_W-1:0] step_o,
    output logic [FRAC_W-1:0] mod_o,
    output logic              cfg_wr_o
);
    localparam int SPARE_W = BUS_W - FRAC_W;
    localparam int HI_W    = CNT_W - BUS_W;

    logic [FRAC_W-1:0]  step_q, mod_q;
    logic [SPARE_W-1:0] step_spare_q, mod_spare_q;
    logic [HI_W-1:0]    hi_hold_q;
    logic [BUS_W-1:0]   rdata_q, rd_mux;
    logic hit_lo, hit_hi, hit_step, hit_mod;

    assign hit_lo   = (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign hit_hi   = (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign hit_step = (bus_addr == ADDR_W'(OFS_STEP));
    assign hit_mod  = (bus_addr == ADDR_W'(OFS_MOD));

    always_comb begin
        rd_mux = '0;
        if (hit_lo)        rd_mux = cnt_i[BUS_W-1:0];
        else if (hit_hi)   rd_mux = BUS_W'(hi_hold_q);
        else if (hit_step) rd_mux = {step_spare_q, step_q};
        else if (hit_mod)  rd_mux = {mod_spare_q, mod_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q       <= FRAC_W'(DEF_STEP);
            mod_q        <= FRAC_W'(DEF_MOD);
            step_spare_q <= '0;
            mod_spare_q  <= '0;
            hi_hold_q    <= CNT_INIT[CNT_W-1:BUS_W];
            rdata_q      <= '0;
        end else begin
            if (bus_wr && hit_step) {step_spare_q, step_q} <= bus_wdata;
            if (bus_wr && hit_mod)  {mod_spare_q, mod_q}   <= bus_wdata;
            if (bus_rd) begin
                rdata_q <= rd_mux;
                if (hit_lo) hi_hold_q <= cnt_i[CNT_W-1:BUS_W];
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign step_o    = step_q;
    assign mod_o     = mod_q;
    assign cfg_wr_o  = bus_wr && (hit_step || hit_mod);

    // R10: the captured high word only moves on a low-word read
    a_r10_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit_lo) |=> $stable(hi_hold_q));

    // R8: read data is steady between reads
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: a write elsewhere leaves the ratio untouched
    a_r9_ratio_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_o |=> ($stable(step_o) && $stable(mod_o)));
endmodule

// File: rtl/fcnt_accum.sv
module fcnt_accum
    import fcnt_pkg::*;
#(
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] step_i,
    input  logic [FRAC_W-1:0] mod_i,
    input  logic              cfg_wr_i,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int SUM_W = FRAC_W + 1;

    acc_state_e        state_q, state_d;
    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  sum;
    logic              adv;

    assign sum = {1'b0, acc_q} + {1'b0, step_i};

    // Next-state decision
    always_comb begin
        if (cfg_wr_i)             state_d = ST_RESTART;
        else if (mod_i == '0)     state_d = ST_STOP;
        else if (step_i >= mod_i) state_d = ST_FULL;
        else                      state_d = ST_RUN;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESTART;
        else        state_q <= state_d;
    end

    // Per-state outputs
    always_comb begin
        acc_d = acc_q;
        adv   = 1'b0;
        unique case (state_q)
            ST_RESTART: acc_d = '0;
            ST_STOP:    acc_d = acc_q;
            ST_FULL: begin
                acc_d = '0;
                adv   = 1'b1;
            end
            ST_RUN: begin
                if (sum >= {1'b0, mod_i}) begin
                    acc_d = FRAC_W'(sum - {1'b0, mod_i});
                    adv   = 1'b1;
                end else begin
                    acc_d = FRAC_W'(sum);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= CNT_INIT;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_q + CNT_W'(adv);
        end
    end

    assign cnt_o = cnt_q;

    // R3: at most one count per cycle, never backwards
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R4: zero modulus freezes the count
    a_r4_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_i == '0) |=> $stable(cnt_q));

    // R5: step at or above modulus advances every cycle
    a_r5_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6: restart cycle clears the fraction and does not advance
    a_r6_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTART) |=> (acc_q == '0 && $stable(cnt_q)));

    // R2: the fraction stays below the modulus while running
    a_r2_frac_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (acc_q < mod_i));
endmodule

// File: rtl/rt_frac_counter.sv
module rt_frac_counter #(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5,
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  count_o
);
    logic [FRAC_W-1:0] step_w, mod_w;
    logic              cfg_wr_w;

    fcnt_regs #(
        .BUS_W(BUS_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
        .CNT_W(CNT_W), .CNT_INIT(CNT_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(count_o), .step_o(step_w), .mod_o(mod_w),
        .cfg_wr_o(cfg_wr_w)
    );

    fcnt_accum #(
        .FRAC_W(FRAC_W), .CNT_W(CNT_W), .CNT_INIT(CNT_INIT)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .step_i(step_w), .mod_i(mod_w), .cfg_wr_i(cfg_wr_w),
        .cnt_o(count_o)
    );
endmodule

// File: tb/sim_rt_frac_counter.sv
module sim_rt_frac_counter;
    localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;

    int checks = 0, failures = 0, cyc = 0;
    string cur_tag = "R1";
    logic [63:0] prev_cnt;
    bit prev_ok = 0;

    // reference state
    logic [63:0] m_cnt;
    logic [31:0] m_rd, m_hi;
    logic [11:0] m_step, m_mod, m_acc;
    logic [19:0] m_ssp, m_msp;
    bit          m_restart;

    always #2 clk = ~clk;

    rt_frac_counter #(.CNT_INIT(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_o(count_o)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = INIT; m_acc = 0; m_step = 4; m_mod = 25;
            m_ssp = 0; m_msp = 0; m_hi = INIT[63:32]; m_rd = 0; m_restart = 1;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    5'h00: begin m_rd = m_cnt[31:0]; m_hi = m_cnt[63:32]; end
                    5'h04: m_rd = m_hi;
                    5'h10: m_rd = {m_ssp, m_step};
                    5'h14: m_rd = {m_msp, m_mod};
                    default: m_rd = 0;
                endcase
            end
            if (m_restart) m_acc = 0;
            else if (m_mod == 0) ;
            else if (m_step >= m_mod) begin m_cnt = m_cnt + 1; m_acc = 0; end
            else begin
                int s;
                s = int'(m_acc) + int'(m_step);
                if (s >= int'(m_mod)) begin m_acc = 12'(s - int'(m_mod)); m_cnt = m_cnt + 1; end
                else m_acc = 12'(s);
            end
            m_restart = bus_wr && (bus_addr == 5'h10 || bus_addr == 5'h14);
            if (bus_wr && bus_addr == 5'h10) {m_ssp, m_step} = bus_wdata;
            if (bus_wr && bus_addr == 5'h14) {m_msp, m_mod} = bus_wdata;
        end
    end

    // per-cycle count comparison (R2/R4/R5 by phase) and step bound (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, count_o, m_cnt);
            if (prev_ok) chk("R3 step", 64'(count_o - prev_cnt <= 64'd1), 64'd1);
            prev_cnt = count_o;
            prev_ok  = 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(string tag, logic [4:0] a, output logic [31:0] v);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
        chk(tag, 64'(v), 64'(m_rd));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // program a ratio, skip the restart cycle, run n cycles, check floor(n*s/m)
    task automatic rate_test(string tag, int s, int m, int n);
        logic [63:0] c0;
        cur_tag = tag;
        wr(5'h10, 32'(s));
        wr(5'h14, 32'(m));
        @(negedge clk);
        c0 = count_o;
        idle(n);
        chk(tag, count_o - c0, 64'((longint'(n) * s) / m));
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        // R1: reset state
        chk("R1 count", count_o, INIT);
        rd("R1 step", 5'h10, v);  chk("R1 step", 64'(v), 64'd4);
        rd("R1 mod", 5'h14, v);   chk("R1 mod", 64'(v), 64'd25);
        rd("R1 hi", 5'h04, v);    chk("R1 hi", 64'(v), 64'(INIT[63:32]));

        // R10: read low, cross the 32-bit carry, then read high
        cur_tag = "R5";
        wr(5'h10, 32'd1);
        wr(5'h14, 32'd1);
        rd("R10 lo", 5'h00, v);
        idle(80);
        chk("R10 carry", 64'(count_o[63:32]), 64'd1);
        rd("R10 hi", 5'h04, v);  chk("R10 hi", 64'(v), 64'd0);
        rd("R10 lo2", 5'h00, v);
        rd("R10 hi2", 5'h04, v); chk("R10 hi2", 64'(v), 64'd1);

        // R2/R4/R5/R6: sweep small ratios
        for (int m = 0; m <= 6; m++) begin
            for (int s = 0; s <= 7; s++) begin
                cur_tag = (m == 0) ? "R4" : ((s >= m) ? "R5" : "R2");
                wr(5'h10, 32'(s));
                cur_tag = "R6";
                wr(5'h14, 32'(m));
                cur_tag = (m == 0) ? "R4" : ((s >= m) ? "R5" : "R2");
                idle(20);
                rd("R8 lo", 5'h00, v);
                rd("R8 hi", 5'h04, v);
            end
        end

        // R2: long-run rate for practical ratios
        rate_test("R2 4/25", 4, 25, 2000);
        rate_test("R2 75/244", 75, 244, 2440);
        rate_test("R2 768/1625", 768, 1625, 3250);
        rate_test("R4 zero mod", 5, 0, 300);
        rate_test("R5 full", 9, 9, 300);

        // R7: spare bits stored, no rate effect
        cur_tag = "R7";
        wr(5'h10, 32'hABCDE003);
        wr(5'h14, 32'h12345007);
        rd("R7 step", 5'h10, v); chk("R7 step", 64'(v), 64'hABCDE003);
        rd("R7 mod", 5'h14, v);  chk("R7 mod", 64'(v), 64'h12345007);
        begin
            logic [63:0] c0;
            c0 = count_o;
            idle(700);
            chk("R7 rate", count_o - c0, 64'd300);
        end

        // R9: writes elsewhere ignored, unmapped reads zero
        cur_tag = "R9";
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'h5555_5555);
        idle(10);
        rd("R9 unmapped", 5'h08, v); chk("R9 unmapped", 64'(v), 64'd0);
        rd("R9 step kept", 5'h10, v); chk("R9 step kept", 64'(v), 64'hABCDE003);

        // R8: rdata holds between reads
        rd("R8 lo", 5'h00, v);
        idle(5);
        chk("R8 hold", 64'(bus_rdata), 64'(v));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule